// File: doc/BRIEF.md
# Parallel Display Bus Write Engine

This block is the host side of a parallel link to a display controller. It takes one command byte, together with a count of data words that follow it, on a valid/ready stream. It places the command and then each data word on a parallel data bus and marks every word with a write pulse. One transaction uses one chip-select window. The data/command line is low for the command word and high for the data words.

Two strobe protocols are available, and a mode input selects one of them for each transaction:

- **Strobe mode (mode 0):** each word is marked by a separate active-low write strobe, and the read strobe stays high.
- **Enable mode (mode 1):** each word is marked by an active-high enable pulse, and a read/write line is held in the write state.

The usable bus width is 8, 9 or 16 bits and is also chosen per transaction. The block also drives the display's reset line low for a programmed number of cycles, and no transaction starts until that pulse is over.

Data words arrive on a second valid/ready stream. Each word is taken when the bus is free. If the source stalls, the chip-select window stays open and no strobe is issued. Strobe low time and high time are parameters.

Top module: `pbus_write_engine`

## Requirements
- R1: In mode 0, each bus word gets exactly one `wrN` low pulse lasting LOW_CYC clocks. `rdN` stays 1, `eStrb` stays 0 and `rwSel` stays 1 at all times.
- R2: In mode 1, each bus word gets exactly one `eStrb` high pulse lasting LOW_CYC clocks. `wrN` and `rdN` stay 1. `rwSel` is 0 exactly while `csN` is 0 and is 1 otherwise.
- R3: `csN` goes low at least one clock before the first strobe of a transaction. It stays low until after the last strobe, and falls only once per transaction. No strobe is ever active while `csN` is high.
- R4: `dcX` is 0 for the command word and 1 for every data word. It is stable for the whole of each strobe.
- R5: `busData` and `dcX` are stable in the clock before a strobe becomes active, throughout the strobe, and in the clock after it ends. When the next data word is already valid, the strobe is inactive for exactly HIGH_CYC+1 clocks between pulses.
- R6: `widthSel` is latched when the command is accepted. The encodings are 0 = 8 bits, 1 = 9 bits, 2 or 3 = 16 bits. Data bits above the selected width are driven 0. The command byte appears on `busData[7:0]`, and all higher bits are 0.
- R7: A command with `cmdLen` = 0 produces exactly one strobe, which is the command word, and then closes the window.
- R8: `done` is high for one clock, and that clock is the one in which `csN` returns high. `cmdReady` is 0 from the clock after acceptance until the window has closed.
- R9: When `rstGo` is seen while idle, `lcdRstN` goes low for max(`rstCycles`, 1) clocks. `rstGo` takes priority over a command offered in the same clock, so `cmdReady` is 0 in that clock. `csN` never goes low while `lcdRstN` is low.
- R10: While a data word is awaited and `dataValid` is low, `csN` stays low and no strobe is issued. Words are put on the bus in the order they are accepted.
- R11: After system reset the outputs are `csN`=1, `wrN`=1, `rdN`=1, `eStrb`=0, `rwSel`=1, `dcX`=0, `busData`=0, `lcdRstN`=1 and `done`=0, and `cmdReady` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous system reset |
| modeSel | input | 1 | Protocol for the next transaction: 0 = write strobe, 1 = enable with read/write line |
| widthSel | input | 2 | Bus width for the next transaction: 0 = 8, 1 = 9, 2 or 3 = 16 bits |
| rstGo | input | 1 | Start a display reset pulse (taken when idle) |
| rstCycles | input | RST_W | Length of the display reset pulse in clocks (0 is treated as 1) |
| cmdValid | input | 1 | Command stream valid |
| cmdReady | output | 1 | Command stream ready (high only when idle and no reset is requested) |
| cmdByte | input | 8 | Command byte |
| cmdLen | input | LEN_W | Number of data words that follow the command |
| dataValid | input | 1 | Data stream valid |
| dataReady | output | 1 | Data stream ready |
| dataWord | input | DATA_W | Data word |
| csN | output | 1 | Chip select, active low |
| dcX | output | 1 | 0 = command word, 1 = data word |
| wrN | output | 1 | Write strobe, active low (mode 0) |
| rdN | output | 1 | Read strobe, held high |
| eStrb | output | 1 | Enable strobe, active high (mode 1) |
| rwSel | output | 1 | Read/write line, 0 = write (mode 1 window) |
| busData | output | DATA_W | Parallel data bus |
| lcdRstN | output | 1 | Display reset, active low |
| done | output | 1 | One-clock pulse when the window closes |

## Verification
A table of transactions covers both protocols, all three bus widths, a redundant width code, command-only transactions and runs of up to five words. Seeds with all ones expose width masking, and the mix of modes shows which strobe pin each mode owns. A monitor records every word at its strobe release and measures setup, hold, pulse width and gap. Comparing those measurements with the data source separates timing faults from data-path faults. Directed cases stall the data source to show that the window is held open, issue a reset together with a command to show that reset has priority, and program a zero reset length to check the one-clock minimum.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  typedef enum logic [1:0] {
    BW8   = 2'd0,
    BW9   = 2'd1,
    BW16  = 2'd2,
    BW16B = 2'd3
  } busWidthE;

  typedef struct packed {
    logic csAct;
    logic dcData;
    logic strbAct;
    logic loadCmd;
    logic loadData;
    logic rstAct;
    logic donePls;
  } ctrlStrobesT;

endpackage

// File: rtl/pbus_ctrl.sv
module pbus_ctrl
  import pbus_pkg::*;
#(
  parameter int LEN_W    = 8,
  parameter int RST_W    = 16,
  parameter int LOW_CYC  = 2,
  parameter int HIGH_CYC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rstGo,
  input  logic [RST_W-1:0] rstCycles,
  input  logic             cmdValid,
  input  logic [LEN_W-1:0] cmdLen,
  input  logic             dataValid,
  output logic             cmdReady,
  output logic             dataReady,
  output ctrlStrobesT      ctrl
);

  localparam int PH_MAX = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam logic [PH_W-1:0] LOW_LAST  = PH_W'(LOW_CYC - 1);
  localparam logic [PH_W-1:0] HIGH_LAST = PH_W'(HIGH_CYC - 1);

  typedef enum logic [2:0] {
    S_IDLE,
    S_RST,
    S_SETUP,
    S_STRB,
    S_HOLD,
    S_WAITD,
    S_CSOFF
  } stateE;

  stateE            state, nxt;
  logic [PH_W-1:0]  phCnt;
  logic [LEN_W-1:0] remCnt;
  logic [RST_W-1:0] rstCnt;
  logic             inData;
  logic             cmdTake, dataTake;

  assign cmdReady  = (state == S_IDLE) && !rstGo;
  assign dataReady = (state == S_WAITD);
  assign cmdTake   = cmdValid && cmdReady;
  assign dataTake  = dataValid && dataReady;

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:  if (rstGo) nxt = S_RST;
               else if (cmdValid) nxt = S_SETUP;
      S_RST:   if (rstCnt == RST_W'(1)) nxt = S_IDLE;
      S_SETUP: nxt = S_STRB;
      S_STRB:  if (phCnt == LOW_LAST) nxt = S_HOLD;
      S_HOLD:  if (phCnt == HIGH_LAST) nxt = (remCnt == '0) ? S_CSOFF : S_WAITD;
      S_WAITD: if (dataValid) nxt = S_STRB;
      S_CSOFF: nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      phCnt  <= '0;
      remCnt <= '0;
      rstCnt <= '0;
      inData <= 1'b0;
    end else begin
      state <= nxt;
      if (state != nxt) phCnt <= '0;
      else if (state == S_STRB || state == S_HOLD) phCnt <= phCnt + 1'b1;

      if (cmdTake) remCnt <= cmdLen;
      else if (dataTake) remCnt <= remCnt - 1'b1;

      if (cmdTake) inData <= 1'b0;
      else if (state == S_HOLD && nxt == S_WAITD) inData <= 1'b1;

      if (state == S_IDLE && rstGo)
        rstCnt <= (rstCycles == '0) ? RST_W'(1) : rstCycles;
      else if (state == S_RST)
        rstCnt <= rstCnt - 1'b1;
    end
  end

  always_comb begin
    ctrl          = '0;
    ctrl.csAct    = (state == S_SETUP) || (state == S_STRB) ||
                    (state == S_HOLD)  || (state == S_WAITD);
    ctrl.dcData   = inData;
    ctrl.strbAct  = (state == S_STRB);
    ctrl.loadCmd  = cmdTake;
    ctrl.loadData = dataTake;
    ctrl.rstAct   = (state == S_RST);
    ctrl.donePls  = (state == S_CSOFF);
  end

  // R10: a starved data wait keeps waiting
  a_r10_wait_holds: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAITD && !dataValid) |=> (state == S_WAITD));

endmodule

// File: rtl/pbus_dpath.sv
module pbus_dpath
  import pbus_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobesT       ctrl,
  input  logic              modeSel,
  input  logic [1:0]        widthSel,
  input  logic [7:0]        cmdByte,
  input  logic [DATA_W-1:0] dataWord,
  output logic              csN,
  output logic              dcX,
  output logic              wrN,
  output logic              rdN,
  output logic              eStrb,
  output logic              rwSel,
  output logic [DATA_W-1:0] busData,
  output logic              lcdRstN,
  output logic              done
);

  logic              modeQ;
  busWidthE          widthQ;
  logic [DATA_W-1:0] maskV;
  logic [DATA_W-1:0] busQ;
  logic              strbPin;

  for (genvar b = 0; b < DATA_W; b++) begin : g_mask
    if (b < 8) begin : g_low
      assign maskV[b] = 1'b1;
    end else if (b == 8) begin : g_nine
      assign maskV[b] = (widthQ != BW8);
    end else begin : g_high
      assign maskV[b] = (widthQ == BW16) || (widthQ == BW16B);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ   <= 1'b0;
      widthQ  <= BW16;
      busQ    <= '0;
      csN     <= 1'b1;
      dcX     <= 1'b0;
      wrN     <= 1'b1;
      eStrb   <= 1'b0;
      rwSel   <= 1'b1;
      lcdRstN <= 1'b1;
      done    <= 1'b0;
    end else begin
      if (ctrl.loadCmd) begin
        modeQ  <= modeSel;
        widthQ <= busWidthE'(widthSel);
        busQ   <= DATA_W'(cmdByte);
      end else if (ctrl.loadData) begin
        busQ <= dataWord & maskV;
      end
      csN     <= !ctrl.csAct;
      dcX     <= ctrl.dcData;
      wrN     <= !(ctrl.strbAct && !modeQ);
      eStrb   <= ctrl.strbAct && modeQ;
      rwSel   <= !(ctrl.csAct && modeQ);
      lcdRstN <= !ctrl.rstAct;
      done    <= ctrl.donePls;
    end
  end

  assign rdN     = 1'b1;
  assign busData = busQ;
  assign strbPin = !wrN || eStrb;

  // R9: chip select only after the display reset is released
  a_r9_no_cs_in_reset: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> lcdRstN);

  // R5: bus held across the strobe and on the clock after it
  a_r5_bus_held: assert property (@(posedge clk) disable iff (!rstN)
    $past(strbPin) |-> $stable(busQ));

  // R4: data/command line steady during a strobe
  a_r4_dc_steady: assert property (@(posedge clk) disable iff (!rstN)
    strbPin |-> $stable(dcX));

  // R8: done marks the chip-select rising clock
  a_r8_done_edge: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (csN && !$past(csN)));

  // R3: no strobe outside the chip-select window
  a_r3_strobe_in_window: assert property (@(posedge clk) disable iff (!rstN)
    strbPin |-> !csN);

endmodule

// File: rtl/pbus_write_engine.sv
module pbus_write_engine
  import pbus_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int LEN_W    = 8,
  parameter int RST_W    = 16,
  parameter int LOW_CYC  = 2,
  parameter int HIGH_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeSel,
  input  logic [1:0]        widthSel,
  input  logic              rstGo,
  input  logic [RST_W-1:0]  rstCycles,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [7:0]        cmdByte,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic              dataValid,
  output logic              dataReady,
  input  logic [DATA_W-1:0] dataWord,
  output logic              csN,
  output logic              dcX,
  output logic              wrN,
  output logic              rdN,
  output logic              eStrb,
  output logic              rwSel,
  output logic [DATA_W-1:0] busData,
  output logic              lcdRstN,
  output logic              done
);

  ctrlStrobesT ctrlS;

  pbus_ctrl #(
    .LEN_W(LEN_W), .RST_W(RST_W), .LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .rstGo(rstGo), .rstCycles(rstCycles),
    .cmdValid(cmdValid), .cmdLen(cmdLen), .dataValid(dataValid),
    .cmdReady(cmdReady), .dataReady(dataReady), .ctrl(ctrlS)
  );

  pbus_dpath #(.DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrlS), .modeSel(modeSel),
    .widthSel(widthSel), .cmdByte(cmdByte), .dataWord(dataWord),
    .csN(csN), .dcX(dcX), .wrN(wrN), .rdN(rdN), .eStrb(eStrb),
    .rwSel(rwSel), .busData(busData), .lcdRstN(lcdRstN), .done(done)
  );

endmodule

// File: tb/pbus_write_engine_tb_top.sv
module pbus_write_engine_tb_top;

  localparam int DW = 16, LW = 8, RW = 16, LOW = 2, HIGH = 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic modeSel = 0, rstGo = 0, cmdValid = 0, dataValid = 0;
  logic [1:0] widthSel = 0;
  logic [RW-1:0] rstCycles = 0;
  logic [7:0] cmdByte = 0;
  logic [LW-1:0] cmdLen = 0;
  logic [DW-1:0] dataWord = 0;
  logic cmdReady, dataReady, csN, dcX, wrN, rdN, eStrb, rwSel, lcdRstN, done;
  logic [DW-1:0] busData;

  always #2 clk = ~clk;

  pbus_write_engine #(.DATA_W(DW), .LEN_W(LW), .RST_W(RW),
                      .LOW_CYC(LOW), .HIGH_CYC(HIGH)) dut_i (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .widthSel(widthSel),
    .rstGo(rstGo), .rstCycles(rstCycles), .cmdValid(cmdValid),
    .cmdReady(cmdReady), .cmdByte(cmdByte), .cmdLen(cmdLen),
    .dataValid(dataValid), .dataReady(dataReady), .dataWord(dataWord),
    .csN(csN), .dcX(dcX), .wrN(wrN), .rdN(rdN), .eStrb(eStrb),
    .rwSel(rwSel), .busData(busData), .lcdRstN(lcdRstN), .done(done));

  int total = 0, bad = 0, cycles = 0;

  // {mode nibble, width nibble, cmd, len, seed}
  localparam logic [39:0] VEC [0:7] = '{
    40'h0_2_2A_03_1234, 40'h0_0_2B_04_FFFF, 40'h0_1_2C_02_01FF,
    40'h1_2_3A_03_A5C3, 40'h1_1_11_00_0000, 40'h0_2_01_00_0000,
    40'h1_0_36_05_8001, 40'h0_3_2C_01_BEEF};

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      report();
    end
  end

  // bus monitor
  bit modeCur = 0;
  int expGap = 0;
  logic [16:0] cap [0:15];
  int capN = 0, doneCnt = 0, csRise = 0, rstLowCnt = 0;
  int setupErr = 0, holdErr = 0, gapErr = 0, csErr = 0, busyErr = 0;
  int widthErr80 = 0, widthErr68 = 0, pinErr80 = 0, pinErr68 = 0;
  bit prevAct = 0, prevCs = 1, prevDc = 0, havePulse = 0;
  logic [DW-1:0] prevBus = 0;
  int lowRun = 0, gapRun = 0;

  always @(negedge clk) begin
    bit act;
    if (rstN) begin
      act = modeCur ? eStrb : !wrN;
      if (!modeCur && (eStrb || !rwSel || !rdN)) pinErr80++;
      if (modeCur && (!wrN || !rdN || rwSel != csN)) pinErr68++;
      if ((act && csN) || (!lcdRstN && !csN)) csErr++;
      if (!csN && cmdReady) busyErr++;
      if (!lcdRstN) rstLowCnt++;
      if (!prevCs && csN) begin csRise++; havePulse = 0; end
      if (done) begin
        doneCnt++;
        if (!(csN && !prevCs)) csErr++;
      end
      if (act && !prevAct) begin
        if (prevBus != busData || prevCs) setupErr++;
        if (havePulse && expGap != 0 && gapRun != expGap) gapErr++;
        lowRun = 0;
      end
      if (act) lowRun++;
      if (!act && prevAct) begin
        if (capN < 16) cap[capN] = {prevDc, prevBus};
        capN++;
        if (busData != prevBus || dcX != prevDc) holdErr++;
        if (lowRun != LOW) begin
          if (modeCur) widthErr68++; else widthErr80++;
        end
        havePulse = 1;
        gapRun = 1;
      end else if (!act && !csN) gapRun++;
      prevAct = act; prevCs = csN; prevDc = dcX; prevBus = busData;
    end
  end

  function automatic logic [15:0] maskOf(input logic [1:0] w);
    return (w == 2'd0) ? 16'h00FF : (w == 2'd1) ? 16'h01FF : 16'hFFFF;
  endfunction

  task automatic runTx(input bit m, input logic [1:0] w, input logic [7:0] c,
                       input int n, input logic [15:0] seed, input int stall,
                       input int rstLen, input string req);
    int d0, t, errs;
    logic [16:0] expW;
    modeCur = m; capN = 0; csRise = 0; rstLowCnt = 0;
    expGap = (stall == 0) ? HIGH + 1 : 0;
    d0 = doneCnt;
    @(negedge clk);
    modeSel = m; widthSel = w; cmdByte = c; cmdLen = LW'(n); cmdValid = 1;
    if (rstLen >= 0) begin
      rstGo = 1; rstCycles = RW'(rstLen);
      #1;
      check(cmdReady == 0, "R9", "ready with reset request", cmdReady, 0);
      @(negedge clk);
      rstGo = 0;
    end
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 0;
    check(cmdReady == 0, "R8", "ready after accept", cmdReady, 0);
    for (int i = 0; i < n; i++) begin
      repeat (stall) @(negedge clk);
      dataWord = 16'(seed + 16'(i) * 16'h0F13);
      dataValid = 1;
      while (!dataReady) @(negedge clk);
      @(negedge clk);
      dataValid = 0;
    end
    t = 0;
    while (doneCnt == d0 && t < 400) begin @(negedge clk); t++; end
    check(doneCnt == d0 + 1, "R8", "done pulses", doneCnt - d0, 1);
    check(capN == n + 1, "R7", "strobe count", capN, n + 1);
    check(csRise == 1, "R3", "chip-select windows", csRise, 1);
    errs = 0;
    for (int i = 0; i <= n && i < 16; i++) begin
      if (i == 0) expW = {1'b0, 8'h00, c};
      else expW = {1'b1, 16'(seed + 16'(i - 1) * 16'h0F13) & maskOf(w)};
      if (i < capN && cap[i] != expW) begin
        errs++;
        $display("FAIL %s word %0d actual=%0h expected=%0h", req, i, cap[i], expW);
      end
    end
    check(errs == 0, req, "word mismatches", errs, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R11 reset state
    check(csN && wrN && rdN && !eStrb && rwSel && !dcX && lcdRstN && !done,
          "R11", "idle pins", {csN, wrN, rdN, eStrb, rwSel, dcX, lcdRstN, done},
          8'b11101010);
    check(busData == 0, "R11", "idle bus", busData, 0);
    check(cmdReady == 1, "R11", "idle ready", cmdReady, 1);

    for (int v = 0; v < 8; v++) begin
      logic [39:0] e;
      e = VEC[v];
      runTx(e[36], e[33:32], e[31:24], int'(e[23:16]), e[15:0], 0, -1,
            e[36] ? "R2 R4 R6" : "R1 R4 R6");
    end

    // R10 stalled data source
    runTx(0, 2'd2, 8'h2C, 3, 16'h4321, 4, -1, "R10");
    runTx(1, 2'd1, 8'h2C, 2, 16'h0F0F, 3, -1, "R10");
    // R9 reset before command, priority and minimum length
    runTx(1, 2'd2, 8'h01, 0, 16'h0000, 0, 5, "R9");
    check(rstLowCnt == 5, "R9", "reset low cycles", rstLowCnt, 5);
    runTx(0, 2'd0, 8'h29, 1, 16'h0055, 0, 0, "R9");
    check(rstLowCnt == 1, "R9", "zero-length reset", rstLowCnt, 1);

    repeat (4) @(negedge clk);
    check(setupErr == 0, "R5", "setup violations", setupErr, 0);
    check(holdErr == 0, "R5", "hold violations", holdErr, 0);
    check(gapErr == 0, "R5", "gap mismatches", gapErr, 0);
    check(widthErr80 == 0, "R1", "write strobe width errors", widthErr80, 0);
    check(widthErr68 == 0, "R2", "enable width errors", widthErr68, 0);
    check(pinErr80 == 0, "R1", "mode 0 idle pin errors", pinErr80, 0);
    check(pinErr68 == 0, "R2", "mode 1 pin errors", pinErr68, 0);
    check(csErr == 0, "R3", "window errors", csErr, 0);
    check(busyErr == 0, "R8", "ready inside window", busyErr, 0);
    report();
  end

endmodule